// File: doc/BRIEF.md
# Time-Space-Time Stream Switch

This block is a configurable switch for time-multiplexed word streams. Each of its lines carries one data word, with a valid flag, per clock. The words are grouped into frames of a fixed number of slots. Every input line is buffered for one frame in a ping-pong store. That store is read back in an order set by configuration, which is the first reordering in time. A per-slot selector then picks, for each output line, which input line feeds it. This is the space stage. A second ping-pong store on each output line reorders the slots a second time before the words leave the block.

All routing comes from three small configuration tables: input reordering, space selection and output reordering. They are indexed by output or input line and by the current slot phase, so the same pattern repeats every frame. Each table has two banks. Writes always go to the shadow bank, so the next routing graph can be loaded while the present one keeps running. A swap request exchanges the active and shadow banks for all three tables together at the next frame boundary, for example during a blanking interval. Sources align their words to the `slot_phase` output.

Top module: `tst_switch`

## Requirements
- R1: `slot_phase` is 0 after reset and counts up by one each clock from 0 to SLOTS-1, then wraps to 0. One pass is one frame.
- R2: After reset every `out_valid` bit is 0, every output word is zero, and all three configuration tables in both banks hold zero.
- R3: A word taken on input line l in slot k of frame F is held for reading during frame F+1. The input-reorder entry (kind 2'b00, line l, slot j) gives the buffered slot k that line l presents to the space stage in slot j.
- R4: The space entry (kind 2'b01, line o, slot j) holds a source input line in `cfg_idx` and an enable in `cfg_en`. When the enable is set, output line o takes the word of that source line in slot j.
- R5: The output-reorder entry (kind 2'b10, line o, slot t) gives the slot j of frame F+1 that output line o presents in slot t of frame F+2. Data therefore takes exactly two frames from input to output.
- R6: In a slot whose space entry has the enable cleared, the output line carries a zero word with valid low.
- R7: A word with valid low on the input is carried as zero with valid low. An output word is zero whenever its valid bit is low.
- R8: A configuration write (`cfg_we` high) changes only the shadow bank. Kind 2'b11 writes nothing. The routing in use does not change until a swap.
- R9: A swap request raised in any slot takes effect at the next frame boundary. A request in the last slot takes effect at the boundary that directly follows it. From then on, all three stages use the other bank.
- R10: Several swap requests within one frame cause a single bank exchange.
- R11: Several output lines may select the same input line in the same slot. Each of them receives the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | LINES*W | Input words, line l in bits [l*W +: W] |
| in_valid | input | LINES | Valid flag per input line |
| cfg_we | input | 1 | Write one shadow configuration entry |
| cfg_kind | input | 2 | Table select: 00 input reorder, 01 space, 10 output reorder, 11 none |
| cfg_line | input | log2(LINES) | Line index of the entry |
| cfg_slot | input | log2(SLOTS) | Slot index of the entry |
| cfg_idx | input | max(log2 LINES, log2 SLOTS) | Buffered slot or source line |
| cfg_en | input | 1 | Enable bit of a space entry |
| swap_req | input | 1 | Request a bank exchange at the next frame boundary |
| out_data | output | LINES*W | Output words, line o in bits [o*W +: W] |
| out_valid | output | LINES | Valid flag per output line |
| slot_phase | output | log2(SLOTS) | Current slot within the frame |

## Verification
An output word in slot t of frame F depends on the input words of frame F-2. The reorder and space entries it uses are the active ones in frames F-1 and F. Swaps and shadow writes therefore show at the ports with this two-frame skew. The bench stores its inputs per frame and takes a copy of its own configuration model at each frame start. It predicts every output from these at the falling edge of each cycle, before any input changes, and it checks `slot_phase` in the same cycle it is driven. Swap timing is checked by placing requests in the middle slot, twice in one frame, and in the last slot. Each placement has to show up as a routing change at exactly the predicted frame.

// File: rtl/tst_pkg.sv
package tst_pkg;

  typedef enum logic [1:0] {
    CFG_ITIME = 2'b00,
    CFG_SPACE = 2'b01,
    CFG_OTIME = 2'b10,
    CFG_NONE  = 2'b11
  } cfg_kind_e;

  // width of an index able to address n items
  function automatic int unsigned idx_w(int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  // cyclic slot advance
  function automatic int unsigned next_slot(int unsigned s, int unsigned slots);
    return (s == slots - 1) ? 0 : s + 1;
  endfunction

  // flat table entry for a (line, slot) pair
  function automatic int unsigned cfg_entry(int unsigned line, int unsigned slot,
                                            int unsigned slots);
    return line * slots + slot;
  endfunction

endpackage

// File: rtl/tst_slot_timer.sv
module tst_slot_timer #(
  parameter  int SLOTS = 4,
  localparam int SLW   = tst_pkg::idx_w(SLOTS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           swap_req,
  output logic [SLW-1:0] slot,
  output logic           frame_par,
  output logic           bank
);

  logic pend;
  logic frame_end;
  logic swap_fire;

  assign frame_end = (slot == SLW'(SLOTS - 1));
  assign swap_fire = frame_end && (pend || swap_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot      <= '0;
      frame_par <= 1'b0;
      bank      <= 1'b0;
      pend      <= 1'b0;
    end else begin
      slot <= SLW'(tst_pkg::next_slot(32'(slot), SLOTS));
      if (frame_end) frame_par <= ~frame_par;
      if (swap_fire) begin
        bank <= ~bank;
        pend <= 1'b0;
      end else if (swap_req) begin
        pend <= 1'b1;
      end
    end
  end

  p_slot_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> slot == $past(slot) + 1'b1);

  p_slot_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> slot == '0);

  p_bank_at_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank) |-> $past(frame_end));

  p_pending_served_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && pend) |=> !$stable(bank));

  p_one_exchange_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank) |-> !pend);

endmodule

// File: rtl/tst_cfg_bank.sv
module tst_cfg_bank #(
  parameter  int LINES = 4,
  parameter  int SLOTS = 4,
  parameter  int EW    = 2,
  localparam int LNW   = tst_pkg::idx_w(LINES),
  localparam int SLW   = tst_pkg::idx_w(SLOTS),
  localparam int N     = LINES * SLOTS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bank,
  input  logic                       we,
  input  logic [LNW-1:0]             wr_line,
  input  logic [SLW-1:0]             wr_slot,
  input  logic [EW-1:0]              wr_val,
  input  logic [SLW-1:0]             rd_slot,
  output logic [LINES-1:0][EW-1:0]   rd_val
);

  logic [EW-1:0] mem [2][N];
  int unsigned   wa;

  assign wa = tst_pkg::cfg_entry(32'(wr_line), 32'(wr_slot), SLOTS);

  // writes land in the shadow bank only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int e = 0; e < N; e++) mem[b][e] <= '0;
    end else if (we && wa < N) begin
      mem[~bank][wa] <= wr_val;
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : g_rd
    assign rd_val[g] = mem[bank][tst_pkg::cfg_entry(g, 32'(rd_slot), SLOTS)];
  end

endmodule

// File: rtl/tst_time_stage.sv
module tst_time_stage #(
  parameter  int LINES = 4,
  parameter  int SLOTS = 4,
  parameter  int W     = 8,
  localparam int SLW   = tst_pkg::idx_w(SLOTS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_par,
  input  logic [SLW-1:0]             wr_slot,
  input  logic [LINES-1:0][W-1:0]    wr_data,
  input  logic [LINES-1:0]           wr_valid,
  input  logic [LINES-1:0][SLW-1:0]  rd_idx,
  output logic [LINES-1:0][W-1:0]    rd_data,
  output logic [LINES-1:0]           rd_valid
);

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [W-1:0] dbuf [2][SLOTS];
    logic         vbuf [2][SLOTS];
    logic         hit;

    // one half fills in slot order while the other half is read
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int b = 0; b < 2; b++)
          for (int s = 0; s < SLOTS; s++) begin
            dbuf[b][s] <= '0;
            vbuf[b][s] <= 1'b0;
          end
      end else begin
        dbuf[frame_par][wr_slot] <= wr_valid[l] ? wr_data[l] : '0;
        vbuf[frame_par][wr_slot] <= wr_valid[l];
      end
    end

    if ((1 << SLW) == SLOTS) begin : g_full
      assign hit = 1'b1;
    end else begin : g_part
      assign hit = 32'(rd_idx[l]) < SLOTS;
    end

    assign rd_valid[l] = hit && vbuf[~frame_par][rd_idx[l]];
    assign rd_data[l]  = hit ? dbuf[~frame_par][rd_idx[l]] : '0;
  end

endmodule

// File: rtl/tst_space_stage.sv
module tst_space_stage #(
  parameter  int LINES = 4,
  parameter  int W     = 8,
  localparam int LNW   = tst_pkg::idx_w(LINES)
) (
  input  logic [LINES-1:0][W-1:0]    in_data,
  input  logic [LINES-1:0]           in_valid,
  input  logic [LINES-1:0][LNW:0]    route,
  output logic [LINES-1:0][W-1:0]    out_data,
  output logic [LINES-1:0]           out_valid
);

  for (genvar o = 0; o < LINES; o++) begin : g_out
    logic [LNW-1:0] src;
    logic           ok;

    assign src = route[o][LNW-1:0];

    if ((1 << LNW) == LINES) begin : g_full
      assign ok = route[o][LNW];
    end else begin : g_part
      assign ok = route[o][LNW] && (32'(src) < LINES);
    end

    assign out_valid[o] = ok && in_valid[src];
    assign out_data[o]  = out_valid[o] ? in_data[src] : '0;
  end

endmodule

// File: rtl/tst_switch.sv
module tst_switch #(
  parameter  int LINES = 4,
  parameter  int SLOTS = 4,
  parameter  int W     = 8,
  localparam int LNW   = tst_pkg::idx_w(LINES),
  localparam int SLW   = tst_pkg::idx_w(SLOTS),
  localparam int IW    = (LNW > SLW) ? LNW : SLW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LINES*W-1:0]   in_data,
  input  logic [LINES-1:0]     in_valid,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_kind,
  input  logic [LNW-1:0]       cfg_line,
  input  logic [SLW-1:0]       cfg_slot,
  input  logic [IW-1:0]        cfg_idx,
  input  logic                 cfg_en,
  input  logic                 swap_req,
  output logic [LINES*W-1:0]   out_data,
  output logic [LINES-1:0]     out_valid,
  output logic [SLW-1:0]       slot_phase
);

  logic [SLW-1:0] slot;
  logic           frame_par;
  logic           bank;

  logic [LINES-1:0][W-1:0]   in_w, mid_d, sp_d, out_w;
  logic [LINES-1:0]          mid_v, sp_v;
  logic [LINES-1:0][SLW-1:0] it_sel, ot_sel;
  logic [LINES-1:0][LNW:0]   sp_sel;

  assign in_w       = in_data;
  assign out_data   = out_w;
  assign slot_phase = slot;

  tst_slot_timer #(.SLOTS(SLOTS)) timer_i (
    .clk(clk), .rst_n(rst_n), .swap_req(swap_req),
    .slot(slot), .frame_par(frame_par), .bank(bank)
  );

  tst_cfg_bank #(.LINES(LINES), .SLOTS(SLOTS), .EW(SLW)) it_cfg_i (
    .clk(clk), .rst_n(rst_n), .bank(bank),
    .we(cfg_we && cfg_kind == tst_pkg::CFG_ITIME),
    .wr_line(cfg_line), .wr_slot(cfg_slot), .wr_val(cfg_idx[SLW-1:0]),
    .rd_slot(slot), .rd_val(it_sel)
  );

  tst_cfg_bank #(.LINES(LINES), .SLOTS(SLOTS), .EW(LNW + 1)) sp_cfg_i (
    .clk(clk), .rst_n(rst_n), .bank(bank),
    .we(cfg_we && cfg_kind == tst_pkg::CFG_SPACE),
    .wr_line(cfg_line), .wr_slot(cfg_slot), .wr_val({cfg_en, cfg_idx[LNW-1:0]}),
    .rd_slot(slot), .rd_val(sp_sel)
  );

  tst_cfg_bank #(.LINES(LINES), .SLOTS(SLOTS), .EW(SLW)) ot_cfg_i (
    .clk(clk), .rst_n(rst_n), .bank(bank),
    .we(cfg_we && cfg_kind == tst_pkg::CFG_OTIME),
    .wr_line(cfg_line), .wr_slot(cfg_slot), .wr_val(cfg_idx[SLW-1:0]),
    .rd_slot(slot), .rd_val(ot_sel)
  );

  tst_time_stage #(.LINES(LINES), .SLOTS(SLOTS), .W(W)) in_stage_i (
    .clk(clk), .rst_n(rst_n), .frame_par(frame_par), .wr_slot(slot),
    .wr_data(in_w), .wr_valid(in_valid), .rd_idx(it_sel),
    .rd_data(mid_d), .rd_valid(mid_v)
  );

  tst_space_stage #(.LINES(LINES), .W(W)) space_i (
    .in_data(mid_d), .in_valid(mid_v), .route(sp_sel),
    .out_data(sp_d), .out_valid(sp_v)
  );

  tst_time_stage #(.LINES(LINES), .SLOTS(SLOTS), .W(W)) out_stage_i (
    .clk(clk), .rst_n(rst_n), .frame_par(frame_par), .wr_slot(slot),
    .wr_data(sp_d), .wr_valid(sp_v), .rd_idx(ot_sel),
    .rd_data(out_w), .rd_valid(out_valid)
  );

  for (genvar o = 0; o < LINES; o++) begin : g_chk
    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid[o] |-> out_w[o] == '0);
  end

endmodule

// File: tb/tst_switch_tb_top.sv
module tst_switch_tb_top;
  localparam int L = 4, S = 4, W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [L*W-1:0] in_data = '0;
  logic [L-1:0]   in_valid = '0;
  logic           cfg_we = 1'b0, cfg_en = 1'b0, swap_req = 1'b0;
  logic [1:0]     cfg_kind = 2'b11, cfg_line = '0, cfg_slot = '0, cfg_idx = '0;
  logic [L*W-1:0] out_data;
  logic [L-1:0]   out_valid;
  logic [1:0]     slot_phase;

  tst_switch dut_i (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_line(cfg_line), .cfg_slot(cfg_slot),
    .cfg_idx(cfg_idx), .cfg_en(cfg_en), .swap_req(swap_req),
    .out_data(out_data), .out_valid(out_valid), .slot_phase(slot_phase)
  );

  typedef struct {
    int line; int frame; int slot;
    logic [W-1:0] d; logic v; string tag;
  } exp_t;

  exp_t expq[$];
  event chk_ev;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model of the configuration banks and per-frame copies
  int m_it[2][L][S], m_src[2][L][S], m_ot[2][L][S];
  bit m_en[2][L][S];
  int s_it[4][L][S], s_src[4][L][S], s_ot[4][L][S];
  bit s_en[4][L][S];
  logic [W-1:0] h_d[4][L][S];
  bit h_v[4][L][S];
  int frame = 0, slot = 0, valid_pct = 100;
  bit bank = 0, pend = 0;
  string phase_tag = "R2";

  // monitor: pops predictions and compares with the ports
  initial forever begin
    @(chk_ev);
    while (expq.size() > 0) begin
      exp_t e;
      e = expq.pop_front();
      n_chk++;
      if (out_valid[e.line] !== e.v || out_data[e.line*W +: W] !== e.d) begin
        n_bad++;
        $display("FAIL %s line %0d frame %0d slot %0d: actual v=%0b d=%02h, expected v=%0b d=%02h",
                 e.tag, e.line, e.frame, e.slot, out_valid[e.line], out_data[e.line*W +: W],
                 e.v, e.d);
      end
    end
  end

  task automatic snapshot();
    for (int l = 0; l < L; l++)
      for (int s = 0; s < S; s++) begin
        s_it[frame%4][l][s]  = m_it[bank][l][s];
        s_src[frame%4][l][s] = m_src[bank][l][s];
        s_en[frame%4][l][s]  = m_en[bank][l][s];
        s_ot[frame%4][l][s]  = m_ot[bank][l][s];
      end
  endtask

  // R3 R4 R5: two-frame path through input reorder, space select, output reorder
  task automatic predict();
    for (int o = 0; o < L; o++) begin
      exp_t e;
      e.line = o; e.frame = frame; e.slot = slot; e.v = 1'b0; e.d = '0; e.tag = phase_tag;
      if (frame >= 2) begin
        int fa = (frame - 1) % 4;
        int fb = (frame - 2) % 4;
        int j  = s_ot[frame%4][o][slot];
        int l  = s_src[fa][o][j];
        int k  = s_it[fa][l][j];
        if (s_en[fa][o][j] && h_v[fb][l][k]) begin
          e.v = 1'b1;
          e.d = h_d[fb][l][k];
        end
      end
      expq.push_back(e);
    end
    -> chk_ev;
  endtask

  task automatic cycle(bit we = 0, int kind = 3, int line = 0, int sl = 0,
                       int idx = 0, bit en = 0, bit sw = 0);
    n_chk++;
    if (slot_phase !== 2'(slot)) begin
      n_bad++;
      $display("FAIL R1 slot_phase: actual %0d expected %0d", slot_phase, slot);
    end
    predict();
    #1;
    for (int l = 0; l < L; l++) begin
      logic [W-1:0] d = W'($urandom);
      bit v = ($urandom % 100) < valid_pct;
      in_data[l*W +: W] = d;
      in_valid[l] = v;
      h_d[frame%4][l][slot] = d;
      h_v[frame%4][l][slot] = v;
    end
    cfg_we = we; cfg_kind = 2'(kind); cfg_line = 2'(line); cfg_slot = 2'(sl);
    cfg_idx = 2'(idx); cfg_en = en; swap_req = sw;
    @(posedge clk);
    if (we) begin
      case (kind)
        0: m_it[!bank][line][sl] = idx;
        1: begin m_en[!bank][line][sl] = en; m_src[!bank][line][sl] = idx; end
        2: m_ot[!bank][line][sl] = idx;
        default: ;
      endcase
    end
    if (slot == S - 1) begin
      if (pend || sw) begin bank = !bank; pend = 0; end
      frame++; slot = 0;
      snapshot();
    end else begin
      slot++;
      if (sw) pend = 1;
    end
    @(negedge clk);
    cfg_we = 1'b0; swap_req = 1'b0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic go_slot(int target);
    while (slot != target) cycle();
  endtask

  // set 0: straight through, one disabled slot; set 1: reversed, rotated, fan-out
  task automatic load(int set);
    for (int l = 0; l < L; l++)
      for (int s = 0; s < S; s++) begin
        int it  = (set == 0) ? s : S - 1 - s;
        int src = (set == 0) ? l : ((s == 0 && l < 2) ? 2 : (l + 1) % L);
        bit en  = (set == 0) ? !(l == 3 && s == 2) : 1'b1;
        int ot  = (set == 0) ? s : (s + 1) % S;
        cycle(1, 0, l, s, it);
        cycle(1, 1, l, s, src, en);
        cycle(1, 2, l, s, ot);
        cycle(1, 3, l, s, (it + 1) % S, 1); // kind 11 writes nothing (R8)
      end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    snapshot();
    // R2: reset state at the ports
    n_chk++;
    if (out_valid !== '0 || out_data !== '0 || slot_phase !== 2'd0) begin
      n_bad++;
      $display("FAIL R2 reset: actual v=%0h d=%0h ph=%0d expected v=0 d=0 ph=0",
               out_valid, out_data, slot_phase);
    end
    phase_tag = "R2 R6";
    run(12);
    phase_tag = "R8 R6";
    load(0);
    // R9 R10: two requests in one frame, the first mid-frame
    go_slot(1);
    phase_tag = "R9 R10";
    cycle(0, 3, 0, 0, 0, 0, 1);
    cycle(0, 3, 0, 0, 0, 0, 1);
    phase_tag = "R3 R4 R5 R6 R9 R10";
    run(20);
    valid_pct = 70;
    phase_tag = "R7 R8";
    load(1);
    // R9: request in the last slot
    go_slot(S - 1);
    cycle(0, 3, 0, 0, 0, 0, 1);
    phase_tag = "R3 R4 R5 R7 R9 R11";
    run(24);
    // swap back to the earlier graph, requested in slot 0
    phase_tag = "R9";
    cycle(0, 3, 0, 0, 0, 0, 1);
    run(16);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule